// File: doc/BRIEF.md
# Cache Test Register Access Unit

This unit lets software inspect and load a small set-associative cache array directly, without normal lookup or refill traffic. A line is moved one 32-bit word at a time through two line-wide staging buffers. Words go into a fill buffer, and words come out of a flush buffer. Commands held in a control register move a whole line between a buffer and a chosen cache entry, or invalidate the whole array.

Software uses a plain synchronous register port with no wait states. A write is captured on the rising clock edge where `wr_en` is high. Read data is combinational from `addr`. The unit has three registers:

- a data window at address 0,
- a tag register at address 1,
- a control register at address 2.

Writing the control register starts its command, which runs on the next clock edge. Cache geometry defaults to 64 sets and 4 ways, and both are parameters.

Top module: `cachetest_access`

## Requirements
- R1: After reset, the control and tag registers read 0, every entry's valid bit is 0, and the data and tag contents of the array are left uninitialised.
- R2: Address 0 is the data window, address 1 is the tag register and address 2 is the control register. The tag and control registers read back the last value written. Address 3 reads 0 and ignores writes.
- R3: The control fields are as follows. Bits [1:0] are the operation: 00 buffer access, 01 line write, 10 line read, 11 invalidate all. Bits [3:2] are the word index, where index k selects buffer bits [32k+31:32k]. Bits [4+:log2(SETS)] are the set. The log2(WAYS) bits directly above the set are the way.
- R4: While the operation field is 00, a data-window write stores its 32-bit value into the fill-buffer word chosen by the word index. The other three words are unchanged.
- R5: A data-window read always returns the flush-buffer word chosen by the word index.
- R6: While the operation field is not 00, data-window writes leave the fill buffer unchanged.
- R7: A line write copies the full 128-bit fill buffer into the addressed entry. It takes that entry's tag from tag-register bits [31:3], its dirty bit from bit 2 and its valid bit from bit 1. It leaves the entry's LRU bit alone.
- R8: A line read copies the addressed entry's 128 bits into the flush buffer. It loads the tag register with the tag in [31:3], dirty in bit 2, valid in bit 1 and LRU in bit 0. This update takes priority over a tag-register write on the same edge.
- R9: Invalidate-all clears every valid bit on a single edge and leaves tags, dirty bits and line data intact.
- R10: A command runs on the clock edge after the control write that carries it, using that control value. Its results are first visible in the cycle after it runs.
- R11: Each entry's LRU bit comes out of reset as 1 for the highest way and 0 for every other way. No command changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Combinational read value of the selected register |

## Verification
The assertions assume that at most one register is written per cycle, and that `addr` and `wr_data` are known whenever `wr_en` is high. They also assume that software does not write the tag register on the edge where a line read runs. The stimulus drives every write for exactly one cycle from the falling edge. It leaves at least one cycle between a line-read command and any later tag-register write. It reads back only entries that were written first, except when it checks the valid and LRU bits, which are defined from reset.

// File: rtl/cta_pkg.sv
package cta_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LINE_W  = 128;
  localparam int unsigned NWORDS  = LINE_W / WORD_W;
  localparam int unsigned WIDX_W  = $clog2(NWORDS);
  localparam int unsigned TAG_LSB = 3;
  localparam int unsigned TAG_W   = WORD_W - TAG_LSB;

  typedef enum logic [1:0] {
    OP_BUF     = 2'b00,
    OP_LINE_WR = 2'b01,
    OP_LINE_RD = 2'b10,
    OP_INVAL   = 2'b11
  } cta_op_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_TAG  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cta_sel_e;
endpackage

// File: rtl/cta_regfile.sv
module cta_regfile
  import cta_pkg::*;
#(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SETW = $clog2(SETS),
  localparam int unsigned WAYW = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic              ent_dirty,
  input  logic              ent_valid,
  input  logic              ent_lru,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] tag_q,
  output logic              cmd_fire,
  output cta_op_e           op,
  output logic [WIDX_W-1:0] widx,
  output logic [SETW-1:0]   set_idx,
  output logic [WAYW-1:0]   way_idx,
  output logic              fill_we
);
  logic ctrl_we, tag_we, pend_q;

  assign ctrl_we = wr_en && (addr == SEL_CTRL);
  assign tag_we  = wr_en && (addr == SEL_TAG);

  assign op       = cta_op_e'(ctrl_q[1:0]);
  assign widx     = ctrl_q[2 +: WIDX_W];
  assign set_idx  = ctrl_q[4 +: SETW];
  assign way_idx  = ctrl_q[4 + SETW +: WAYW];
  assign cmd_fire = pend_q;
  assign fill_we  = wr_en && (addr == SEL_DATA) && (op == OP_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= ctrl_we;
      if (ctrl_we) ctrl_q <= wr_data;
    end
  end

  // a line read that is running overrides a software write to the tag register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (pend_q && op == OP_LINE_RD) begin
      tag_q <= {ent_tag, ent_dirty, ent_valid, ent_lru};
    end else if (tag_we) begin
      tag_q <= wr_data;
    end
  end
endmodule

// File: rtl/cta_buffers.sv
module cta_buffers
  import cta_pkg::*;
(
  input  logic              clk,
  input  logic              fill_we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flush_ld,
  input  logic [LINE_W-1:0] ent_line,
  output logic [LINE_W-1:0] fill_line,
  output logic [WORD_W-1:0] flush_word
);
  logic [LINE_W-1:0] flush_q;

  for (genvar w = 0; w < NWORDS; w++) begin : g_fill
    always_ff @(posedge clk) begin
      if (fill_we && widx == WIDX_W'(w))
        fill_line[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (flush_ld) flush_q <= ent_line;
  end

  assign flush_word = flush_q[widx*WORD_W +: WORD_W];
endmodule

// File: rtl/cta_store.sv
module cta_store
  import cta_pkg::*;
#(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SETW    = $clog2(SETS),
  localparam int unsigned WAYW    = $clog2(WAYS),
  localparam int unsigned ENTRIES = SETS * WAYS,
  localparam int unsigned IDXW    = SETW + WAYW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_we,
  input  logic               inval_all,
  input  logic [SETW-1:0]    set_idx,
  input  logic [WAYW-1:0]    way_idx,
  input  logic [LINE_W-1:0]  fill_line,
  input  logic [WORD_W-1:0]  tag_reg,
  output logic [LINE_W-1:0]  ent_line,
  output logic [TAG_W-1:0]   ent_tag,
  output logic               ent_dirty,
  output logic               ent_valid,
  output logic               ent_lru,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [LINE_W-1:0] data_m  [ENTRIES];
  logic [TAG_W-1:0]  tag_m   [ENTRIES];
  logic              dirty_m [ENTRIES];
  logic [ENTRIES-1:0] lru_q;
  logic [IDXW-1:0]    idx;

  assign idx = {way_idx, set_idx};

  always_ff @(posedge clk) begin
    if (line_we) begin
      data_m[idx]  <= fill_line;
      tag_m[idx]   <= tag_reg[TAG_LSB +: TAG_W];
      dirty_m[idx] <= tag_reg[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_vec <= '0;
    end else if (inval_all) begin
      valid_vec <= '0;
    end else if (line_we) begin
      valid_vec[idx] <= tag_reg[1];
    end
  end

  // replacement hint: highest way marked from reset, never altered by test commands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < int'(ENTRIES); e++)
        lru_q[e] <= (e >= int'((WAYS - 1) * SETS));
    end else begin
      lru_q <= lru_q;
    end
  end

  assign ent_line  = data_m[idx];
  assign ent_tag   = tag_m[idx];
  assign ent_dirty = dirty_m[idx];
  assign ent_valid = valid_vec[idx];
  assign ent_lru   = lru_q[idx];
endmodule

// File: rtl/cachetest_access.sv
module cachetest_access
  import cta_pkg::*;
#(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam int unsigned SETW    = $clog2(SETS);
  localparam int unsigned WAYW    = $clog2(WAYS);
  localparam int unsigned ENTRIES = SETS * WAYS;

  logic [WORD_W-1:0]  ctrl_q, tag_q, flush_word;
  logic               cmd_fire, fill_we;
  cta_op_e            op;
  logic [WIDX_W-1:0]  widx;
  logic [SETW-1:0]    set_idx;
  logic [WAYW-1:0]    way_idx;
  logic [LINE_W-1:0]  fill_line, ent_line;
  logic [TAG_W-1:0]   ent_tag;
  logic               ent_dirty, ent_valid, ent_lru;
  logic [ENTRIES-1:0] valid_vec;

  cta_regfile #(.SETS(SETS), .WAYS(WAYS)) u_regs (
    .clk, .rst_n, .wr_en, .addr, .wr_data,
    .ent_tag, .ent_dirty, .ent_valid, .ent_lru,
    .ctrl_q, .tag_q, .cmd_fire, .op, .widx, .set_idx, .way_idx, .fill_we
  );

  cta_buffers u_bufs (
    .clk, .fill_we, .widx, .wr_data,
    .flush_ld (cmd_fire && op == OP_LINE_RD),
    .ent_line, .fill_line, .flush_word
  );

  cta_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk, .rst_n,
    .line_we   (cmd_fire && op == OP_LINE_WR),
    .inval_all (cmd_fire && op == OP_INVAL),
    .set_idx, .way_idx, .fill_line,
    .tag_reg (tag_q),
    .ent_line, .ent_tag, .ent_dirty, .ent_valid, .ent_lru, .valid_vec
  );

  always_comb begin
    unique case (cta_sel_e'(addr))
      SEL_DATA: rd_data = flush_word;
      SEL_TAG:  rd_data = tag_q;
      SEL_CTRL: rd_data = ctrl_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cta_checker.sv
module cta_checker
  import cta_pkg::*;
#(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4,
  localparam int unsigned ENTRIES = SETS * WAYS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         addr,
  input logic [31:0]        wr_data,
  input logic               cmd_fire,
  input logic [31:0]        ctrl_q,
  input logic [31:0]        tag_q,
  input logic [LINE_W-1:0]  fill_line,
  input logic [ENTRIES-1:0] valid_vec
);
  logic ctrl_wr, tag_wr, data_wr, rd_run;
  assign ctrl_wr = wr_en && addr == 2'd2;
  assign tag_wr  = wr_en && addr == 2'd1;
  assign data_wr = wr_en && addr == 2'd0;
  assign rd_run  = cmd_fire && ctrl_q[1:0] == 2'b10;

  AST_CMD_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> cmd_fire); // R10

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q)); // R2

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && ctrl_q[1:0] == 2'b11) |=> valid_vec == '0); // R9

  AST_FILL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ctrl_q[1:0] == 2'b00) |=>
      fill_line[$past(ctrl_q[3:2])*32 +: 32] == $past(wr_data)); // R4

  AST_FILL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ctrl_q[1:0] != 2'b00) |=> $stable(fill_line)); // R6

  AST_TAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_wr && !rd_run) |=> tag_q == $past(wr_data)); // R2
endmodule

bind cachetest_access cta_checker #(.SETS(SETS), .WAYS(WAYS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .cmd_fire(cmd_fire), .ctrl_q(ctrl_q), .tag_q(tag_q),
  .fill_line(fill_line), .valid_vec(valid_vec)
);

// File: tb/cachetest_access_tb_top.sv
module cachetest_access_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       req;
  } exp_item_t;

  exp_item_t   exp_q[$];
  logic [31:0] act_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  cachetest_access dut_i (.clk, .rst_n, .wr_en, .addr, .wr_data, .rd_data);

  // all tasks start and end on a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] e,
                        input logic [31:0] m, input string req);
    exp_item_t it;
    addr = a;
    #2;
    it.exp = e; it.mask = m; it.req = req;
    exp_q.push_back(it);
    act_q.push_back(rd_data);
    @(negedge clk);
  endtask

  // monitor: compares observed values against the expectations in order
  initial begin
    forever begin
      @(posedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        exp_item_t it;
        logic [31:0] a;
        it = exp_q.pop_front();
        a  = act_q.pop_front();
        n_cmp++;
        if ((a & it.mask) !== (it.exp & it.mask)) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h (mask %h)", it.req, a, it.exp, it.mask);
        end
      end
    end
  end

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] A0 = 32'h1111_0000, A1 = 32'h2222_0001,
                          A2 = 32'h3333_0002, A3 = 32'h4444_0003;
  localparam logic [31:0] T52 = (32'h12345 << 3) | 32'h6;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state
    rd_chk(2'd2, 32'h0, ALL, "R1 ctrl after reset");
    rd_chk(2'd1, 32'h0, ALL, "R1 tag after reset");
    // line read set0 way0 and set0 way3: valid 0, LRU per R11
    wr(2'd2, 32'h0000_0002); idle();
    rd_chk(2'd1, 32'h0, 32'h3, "R1/R11 way0 valid=0 lru=0");
    wr(2'd2, 32'h0000_0C02); idle();
    rd_chk(2'd1, 32'h1, 32'h3, "R1/R11 way3 valid=0 lru=1");

    // R2 register map
    wr(2'd2, 32'h0000_1234);
    rd_chk(2'd2, 32'h0000_1234, ALL, "R2 ctrl readback");
    wr(2'd3, 32'hCAFE_F00D);
    rd_chk(2'd3, 32'h0, ALL, "R2 unused address reads 0");

    // R4 fill the four words, R3 word index
    wr(2'd2, 32'h0); wr(2'd0, A0);
    wr(2'd2, 32'h4); wr(2'd0, A1);
    wr(2'd2, 32'h8); wr(2'd0, A2);
    wr(2'd2, 32'hC); wr(2'd0, A3);
    wr(2'd1, T52);
    rd_chk(2'd1, T52, ALL, "R2 tag readback");
    // R7 line write set5 way2 (ctrl bits: op01, set<<4, way<<10)
    wr(2'd2, 32'h0000_0851); idle();
    // overwrite fill word 0 afterwards, clear tag register
    wr(2'd2, 32'h0); wr(2'd0, 32'h0000_DEAD);
    wr(2'd1, 32'h0); idle();

    // R8 line read set5 way2; R10 tag old before command edge
    wr(2'd2, 32'h0000_0852);
    rd_chk(2'd1, 32'h0, ALL, "R10 tag unchanged before command edge");
    rd_chk(2'd1, T52, ALL, "R8/R7 tag dirty valid lru after line read");
    // R5 flush-buffer words via index in control register
    wr(2'd2, 32'h0); rd_chk(2'd0, A0, ALL, "R5/R7 word0");
    wr(2'd2, 32'h4); rd_chk(2'd0, A1, ALL, "R5/R3 word1");
    wr(2'd2, 32'h8); rd_chk(2'd0, A2, ALL, "R5/R3 word2");
    wr(2'd2, 32'hC); rd_chk(2'd0, A3, ALL, "R5/R3 word3");

    // R9 invalidate-all, then read set5 way2 back
    wr(2'd2, 32'h3); idle();
    wr(2'd2, 32'h0000_0852); idle();
    rd_chk(2'd1, T52 & ~32'h2, ALL, "R9 valid cleared, tag and dirty kept");
    rd_chk(2'd0, A0, ALL, "R9 line data kept");

    // R6 data write ignored while op is line read
    wr(2'd0, 32'h0000_0BAD);
    wr(2'd1, 32'hFFFF_FFFA); // tag all ones, dirty0 valid1
    // line write top corner: set63 way3
    wr(2'd2, 32'h0000_0FF1); idle();
    wr(2'd2, 32'h0000_0FF2); idle();
    rd_chk(2'd1, 32'hFFFF_FFFB, ALL, "R3/R11 set63 way3 tag, lru=1 untouched");
    wr(2'd2, 32'h0000_0FF0);
    rd_chk(2'd0, 32'h0000_DEAD, ALL, "R6 fill word0 unchanged by ignored write");
    wr(2'd2, 32'h0000_0FF4);
    rd_chk(2'd0, A1, ALL, "R6 fill word1 intact");

    // R9 valid vs other entries: set5 way2 still invalid
    wr(2'd2, 32'h0000_0852); idle();
    rd_chk(2'd1, 32'h0, 32'h3, "R9/R11 set5 way2 valid=0 lru=0");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule